// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port that exchanges 8-bit words with a peer over three lines: a transfer clock, an outgoing data line and an incoming data line. No start, stop or parity bits are used. The transfer clock either comes from an internal divider or is taken from an input pin that the peer drives. Every clock pulse shifts one bit out and one bit in at the same time, so a word can only be received while a word is also being sent.

Software writes outgoing words into a transmit holding register and takes incoming words from a receive holding register. Each holding register sits in front of its own shift register, so the next word can be queued while the current one is on the wire. Control inputs set the clock source and its divide ratio, the clock polarity, the bit order, the moment the transmit interrupt fires and an automatic re-arm of reception. A sticky overrun flag reports a word that arrived while the previous one was still unread.

Top module: `sio_xcvr`

## Requirements
- R1: Each transfer moves exactly 8 bits. It uses 8 leading clock edges (the clock leaves its idle level) and 8 trailing clock edges (the clock returns to idle). After the eighth trailing edge the port is idle again, with the clock at its idle level.
- R2: With the internal clock (`ext_clk_sel`=0), every half period of `sclk_out` lasts (`baud_div`+1)×P system cycles. P is 1 for `pre_sel`=0, 8 for `pre_sel`=1 and 32 for `pre_sel`=2 or 3.
- R3: The clock idles high when `clk_pol`=0 and low when `clk_pol`=1. `txd` changes on leading edges and `rxd` is sampled on trailing edges. With `clk_pol`=0 that means falling and rising edges respectively, and with `clk_pol`=1 the reverse.
- R4: With `msb_first`=0, bit 0 is sent and received first. With `msb_first`=1, bit 7 goes first. The same order applies in both directions.
- R5: A transfer starts only when `tx_en`=1 and the transmit holding register holds a word. `tx_empty` is 1 when the holding register holds no word, and 0 in the cycle after `tx_wr`.
- R6: A word is received only when `rx_en`=1 at the start of the transfer. Otherwise the port still transmits, but `rx_rdata`, `rx_valid` and `rx_irq` are left untouched.
- R7: `tx_irq` is a one-cycle pulse. With `tx_irq_sel`=0 it fires when the holding register is copied into the shift register, before the first leading edge. With `tx_irq_sel`=1 it fires together with the eighth trailing edge.
- R8: When a received word moves into the receive holding register and no overrun is pending, `rx_irq` pulses for one cycle. `rx_valid` (holding register full and no overrun) is then 1. A `rx_rd` pulse empties the register.
- R9: `overrun` is set at the seventh trailing edge of a received word if the previous word is still unread. A read before that edge prevents it. While `overrun` is set, `rx_valid` is 0 and no `rx_irq` is raised. The flag holds until `ovr_clr` is pulsed or `rx_en` goes to 0.
- R10: With `cont_rx`=1 and `rx_en`=1, a `rx_rd` pulse starts a new transfer even when the transmit holding register is empty. In that transfer `txd` sends all ones and `tx_irq` is not raised with `tx_irq_sel`=0. With `cont_rx`=0, a read starts nothing.
- R11: With `ext_clk_sel`=1, the leading and trailing edges come from `sclk_in` through a two-stage synchronizer. In this mode `sclk_oe` is 0.
- R12: After reset, `tx_empty`=1, `rx_valid`=0, `overrun`=0, `txd`=1, both interrupts are 0, and `sclk_out` is at the idle level for `clk_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable; low also clears overrun |
| ext_clk_sel | input | 1 | 1: transfer clock from `sclk_in` |
| clk_pol | input | 1 | Clock polarity select |
| msb_first | input | 1 | Bit order select |
| tx_irq_sel | input | 1 | 0: interrupt on buffer copy, 1: on completion |
| cont_rx | input | 1 | Re-arm reception on each receive read |
| pre_sel | input | 2 | Prescaler select (1, 8, 32) |
| baud_div | input | 8 | Divider value n |
| tx_wr | input | 1 | Write pulse for transmit holding register |
| tx_wdata | input | 8 | Word to transmit |
| rx_rd | input | 1 | Read pulse for receive holding register |
| ovr_clr | input | 1 | Clear pulse for overrun |
| rx_rdata | output | 8 | Receive holding register |
| rx_valid | output | 1 | Holding register full and no overrun |
| tx_empty | output | 1 | Transmit holding register empty |
| overrun | output | 1 | Sticky overrun flag |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internal transfer clock |
| sclk_oe | output | 1 | High when `sclk_out` should drive the line |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
The assertions assume that `clk_pol` changes only while the port is idle, so that the idle-level check sees a settled clock. They also assume that `tx_wr`, `rx_rd` and `ovr_clr` are single-cycle pulses. In external-clock mode the peer must keep `sclk_in` at the idle level between words and hold each half period well above the synchronizer delay. The bench changes configuration only between transfers and drives every pulse for exactly one cycle. Its external clock uses six-cycle half periods, and its peer model changes `rxd` only on leading edges.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        PRE_DIV1  = 2'd0,
        PRE_DIV8  = 2'd1,
        PRE_DIV32 = 2'd2
    } pre_sel_e;

    localparam int PRE_W = 5;

    // Last count of the prescaler for a given selection.
    function automatic logic [PRE_W-1:0] pre_last(input pre_sel_e s);
        case (s)
            PRE_DIV1: pre_last = PRE_W'(0);
            PRE_DIV8: pre_last = PRE_W'(7);
            default:  pre_last = PRE_W'(31);
        endcase
    endfunction

endpackage

// File: rtl/sio_baud.sv
module sio_baud
    import sio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  pre_sel_e         pre_sel,
    input  logic [DIV_W-1:0] div,
    output logic             half_tick
);

    typedef struct packed {
        logic [PRE_W-1:0] pre_cnt;
        logic [DIV_W-1:0] div_cnt;
    } baud_t;

    baud_t q, d;
    logic  pre_wrap;

    assign pre_wrap  = (q.pre_cnt == pre_last(pre_sel));
    assign half_tick = run && pre_wrap && (q.div_cnt == div);

    always_comb begin
        d = q;
        if (!run) begin
            d.pre_cnt = '0;
            d.div_cnt = '0;
        end else if (pre_wrap) begin
            d.pre_cnt = '0;
            if (q.div_cnt == div) d.div_cnt = '0;
            else                  d.div_cnt = q.div_cnt + 1'b1;
        end else begin
            d.pre_cnt = q.pre_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/sio_sync_edge.sv
module sio_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);

    logic [STAGES:0] sh_q, sh_d;

    always_comb sh_d = {sh_q[STAGES-1:0], async_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/sio_xcvr.sv
module sio_xcvr
    import sio_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              ext_clk_sel,
    input  logic              clk_pol,
    input  logic              msb_first,
    input  logic              tx_irq_sel,
    input  logic              cont_rx,
    input  logic [1:0]        pre_sel,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    input  logic              rx_rd,
    input  logic              ovr_clr,
    output logic [WORD_W-1:0] rx_rdata,
    output logic              rx_valid,
    output logic              tx_empty,
    output logic              overrun,
    output logic              tx_irq,
    output logic              rx_irq,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              txd,
    input  logic              rxd
);

    localparam int                CNT_W    = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0]  OVR_BIT  = CNT_W'(WORD_W - 2);

    typedef struct packed {
        logic [WORD_W-1:0] tbuf;
        logic              tbuf_full;
        logic [WORD_W-1:0] rbuf;
        logic              rbuf_full;
        logic [WORD_W-1:0] tsr;
        logic [WORD_W-1:0] rsr;
        logic              busy;
        logic              rx_act;
        logic              phase;
        logic [CNT_W-1:0]  cnt;
        logic              txd;
        logic              ovr;
        logic              rearm;
        logic              tx_irq;
        logic              rx_irq;
    } st_t;

    st_t q, d;

    logic busy;
    logic half_tick, ext_rise, ext_fall;
    logic lead_src, trail_src, lead, trail, start;
    logic [WORD_W-1:0] rsr_nx;

    assign busy = q.busy;

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (q.busy & ~ext_clk_sel),
        .pre_sel   (pre_sel_e'(pre_sel)),
        .div       (baud_div),
        .half_tick (half_tick)
    );

    sio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    // Leading edge leaves the idle level, trailing edge returns to it.
    assign lead_src  = ext_clk_sel ? (clk_pol ? ext_rise : ext_fall) : half_tick;
    assign trail_src = ext_clk_sel ? (clk_pol ? ext_fall : ext_rise) : half_tick;
    assign lead      = q.busy & ~q.phase & lead_src;
    assign trail     = q.busy &  q.phase & trail_src;

    assign start = ~q.busy & tx_en &
                   (q.tbuf_full | (q.rearm & rx_en & cont_rx));

    assign rsr_nx = msb_first ? {q.rsr[WORD_W-2:0], rxd}
                              : {rxd, q.rsr[WORD_W-1:1]};

    always_comb begin
        d        = q;
        d.tx_irq = 1'b0;
        d.rx_irq = 1'b0;

        if (start) begin
            d.busy   = 1'b1;
            d.phase  = 1'b0;
            d.cnt    = '0;
            d.rx_act = rx_en;
            d.rearm  = 1'b0;
            if (q.tbuf_full) begin
                d.tsr       = q.tbuf;
                d.tbuf_full = 1'b0;
                if (!tx_irq_sel) d.tx_irq = 1'b1;
            end else begin
                d.tsr = '1;
            end
        end

        if (rx_rd) begin
            d.rbuf_full = 1'b0;
            if (cont_rx && rx_en) d.rearm = 1'b1;
        end

        if (ovr_clr || !rx_en)  d.ovr   = 1'b0;
        if (!rx_en || !cont_rx) d.rearm = 1'b0;

        if (lead) begin
            d.phase = 1'b1;
            d.txd   = msb_first ? q.tsr[WORD_W-1] : q.tsr[0];
            d.tsr   = msb_first ? (q.tsr << 1) : (q.tsr >> 1);
        end

        if (trail) begin
            d.phase = 1'b0;
            d.cnt   = q.cnt + 1'b1;
            if (q.rx_act) d.rsr = rsr_nx;
            if (q.rx_act && q.cnt == OVR_BIT && q.rbuf_full && !rx_rd)
                d.ovr = 1'b1;
            if (q.cnt == LAST_BIT) begin
                d.busy = 1'b0;
                if (tx_irq_sel) d.tx_irq = 1'b1;
                if (q.rx_act) begin
                    d.rbuf      = rsr_nx;
                    d.rbuf_full = 1'b1;
                    if (!d.ovr) d.rx_irq = 1'b1;
                end
            end
        end

        if (tx_wr) begin
            d.tbuf      = tx_wdata;
            d.tbuf_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.txd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_rdata = q.rbuf;
    assign rx_valid = q.rbuf_full & ~q.ovr;
    assign tx_empty = ~q.tbuf_full;
    assign overrun  = q.ovr;
    assign tx_irq   = q.tx_irq;
    assign rx_irq   = q.rx_irq;
    assign txd      = q.txd;
    assign sclk_oe  = ~ext_clk_sel;
    assign sclk_out = ext_clk_sel ? ~clk_pol : (~clk_pol ^ q.phase);

endmodule

// File: rtl/sio_xcvr_chk.sv
module sio_xcvr_chk (
    input logic clk,
    input logic rst_n,
    input logic clk_pol,
    input logic busy,
    input logic sclk_out,
    input logic tx_wr,
    input logic tx_empty,
    input logic tx_irq,
    input logic rx_irq,
    input logic overrun,
    input logic ovr_clr,
    input logic rx_en,
    input logic rx_valid
);

    p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk_out == ~clk_pol));

    p_wr_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_empty);

    p_txirq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    p_rxirq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    p_rxirq_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_valid);

    p_valid_no_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !overrun);

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr && rx_en) |=> overrun);

    p_ovr_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !rx_irq);

endmodule

bind sio_xcvr sio_xcvr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_pol  (clk_pol),
    .busy     (busy),
    .sclk_out (sclk_out),
    .tx_wr    (tx_wr),
    .tx_empty (tx_empty),
    .tx_irq   (tx_irq),
    .rx_irq   (rx_irq),
    .overrun  (overrun),
    .ovr_clr  (ovr_clr),
    .rx_en    (rx_en),
    .rx_valid (rx_valid)
);

// File: tb/sio_xcvr_tb.sv
module sio_xcvr_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic tx_en = 1'b1, rx_en = 1'b1, ext_sel = 1'b0, clk_pol = 1'b0;
    logic msb = 1'b0, irq_sel = 1'b0, cont_rx = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic [7:0] baud_div = 8'd1;
    logic tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic sclk_in = 1'b1, rxd = 1'b1;
    logic [7:0] rx_rdata;
    logic rx_valid, tx_empty, overrun, tx_irq, rx_irq, sclk_out, sclk_oe, txd;

    sio_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .ext_clk_sel(ext_sel), .clk_pol(clk_pol), .msb_first(msb),
        .tx_irq_sel(irq_sel), .cont_rx(cont_rx), .pre_sel(pre_sel),
        .baud_div(baud_div), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .rx_rd(rx_rd), .ovr_clr(ovr_clr), .rx_rdata(rx_rdata),
        .rx_valid(rx_valid), .tx_empty(tx_empty), .overrun(overrun),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .txd(txd), .rxd(rxd)
    );

    int checks = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic get_bit(input logic [7:0] w, input int i, input logic m);
        return m ? w[7-i] : w[i];
    endfunction

    function automatic logic [7:0] put_bit(input logic [7:0] w, input int i,
                                           input logic m, input logic b);
        logic [7:0] r = w;
        if (m) r[7-i] = b; else r[i] = b;
        return r;
    endfunction

    function automatic int half_cycles(input logic [1:0] ps, input logic [7:0] n);
        int p = (ps == 2'd0) ? 1 : (ps == 2'd1) ? 8 : 32;
        return (int'(n) + 1) * p;
    endfunction

    // Peer model for the internal clock
    logic armed = 1'b0;
    logic sclk_prev = 1'b1;
    logic [7:0] peer_tx = 8'h00, peer_rx = 8'h00;
    int lead_n = 0, trail_n = 0, half_len = 0, last_tog = 0;
    int first_lead_cyc = 0, last_trail_cyc = 0;
    int txirq_n = 0, rxirq_n = 0, txirq_cyc = 0;

    always @(negedge clk) begin
        if (tx_irq) begin txirq_n++; txirq_cyc = cyc; end
        if (rx_irq) rxirq_n++;
        if (armed && !ext_sel && sclk_out !== sclk_prev) begin
            half_len = cyc - last_tog;
            last_tog = cyc;
            if (sclk_out != ~clk_pol) begin
                if (lead_n == 0) first_lead_cyc = cyc;
                if (lead_n < 8) rxd = get_bit(peer_tx, lead_n, msb);
                lead_n++;
            end else begin
                if (trail_n < 8) peer_rx = put_bit(peer_rx, trail_n, msb, txd);
                trail_n++;
                last_trail_cyc = cyc;
            end
        end
        sclk_prev = sclk_out;
    end

    task automatic arm_peer(input logic [7:0] pw);
        peer_tx = pw; peer_rx = 8'h00; lead_n = 0; trail_n = 0;
        last_tog = cyc; armed = 1'b1;
    endtask

    task automatic write_tx(input logic [7:0] tw);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = tw;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_trails(input int k);
        int g = 0;
        while (trail_n < k && g < 20000) begin @(negedge clk); g++; end
    endtask

    task automatic wait_done();
        wait_trails(8);
        repeat (3) @(negedge clk);
        armed = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tw, input logic [7:0] pw);
        arm_peer(pw);
        write_tx(tw);
        wait_done();
    endtask

    task automatic pulse_ovr_clr();
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] tw, pw, prev_rb;
        int ti, ri;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);

        // R12 reset state
        chk(tx_empty == 1'b1, "R12", "tx_empty", tx_empty, 1);
        chk(rx_valid == 1'b0 && overrun == 1'b0, "R12", "valid/ovr", {rx_valid, overrun}, 0);
        chk(txd == 1'b1 && sclk_out == 1'b1, "R12", "txd/sclk", {txd, sclk_out}, 3);
        chk(tx_irq == 1'b0 && rx_irq == 1'b0, "R12", "irqs", {tx_irq, rx_irq}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1/R4/R7/R8/R2: randomized transfers
        for (int k = 0; k < 24; k++) begin
            tw = 8'($urandom); pw = 8'($urandom);
            @(negedge clk);
            msb = 1'($urandom); clk_pol = 1'($urandom); irq_sel = 1'($urandom);
            pre_sel = 2'($urandom % 2); baud_div = 8'($urandom % 3);
            @(negedge clk);
            chk(sclk_out == ~clk_pol, "R3", "idle level", sclk_out, ~clk_pol);
            ti = txirq_n; ri = rxirq_n;
            xfer(tw, pw);
            chk(peer_rx == tw, "R1", "peer captured", peer_rx, tw);
            chk(rx_rdata == pw, "R4", "rx word", rx_rdata, pw);
            chk(rx_valid == 1'b1, "R8", "rx_valid", rx_valid, 1);
            chk(rxirq_n - ri == 1, "R8", "rx_irq count", rxirq_n - ri, 1);
            chk(txirq_n - ti == 1, "R7", "tx_irq count", txirq_n - ti, 1);
            if (irq_sel)
                chk(txirq_cyc >= last_trail_cyc, "R7", "tx_irq at completion", txirq_cyc, last_trail_cyc);
            else
                chk(txirq_cyc < first_lead_cyc, "R7", "tx_irq at copy", txirq_cyc, first_lead_cyc);
            chk(half_len == half_cycles(pre_sel, baud_div), "R2", "half period",
                half_len, half_cycles(pre_sel, baud_div));
            chk(lead_n == 8 && trail_n == 8, "R1", "edge count", lead_n * 16 + trail_n, 8 * 16 + 8);
            chk(sclk_out == ~clk_pol, "R1", "idle after", sclk_out, ~clk_pol);
            read_rx();
            chk(rx_valid == 1'b0, "R8", "valid after read", rx_valid, 0);
        end

        // R2: divide by 32 prescaler
        @(negedge clk); msb = 1'b0; clk_pol = 1'b0; irq_sel = 1'b0; pre_sel = 2'd2; baud_div = 8'd0;
        xfer(8'hA5, 8'h3C);
        chk(half_len == 32, "R2", "div32 half period", half_len, 32);
        chk(peer_rx == 8'hA5, "R2", "div32 word", peer_rx, 8'hA5);
        read_rx();
        @(negedge clk); pre_sel = 2'd0; baud_div = 8'd3;

        // R5: no start while transmit disabled
        @(negedge clk); tx_en = 1'b0;
        arm_peer(8'h11);
        write_tx(8'h5A);
        repeat (200) @(negedge clk);
        chk(lead_n == 0, "R5", "no clock while disabled", lead_n, 0);
        chk(tx_empty == 1'b0, "R5", "tx_empty held", tx_empty, 0);
        tx_en = 1'b1;
        wait_done();
        chk(peer_rx == 8'h5A, "R5", "sent after enable", peer_rx, 8'h5A);
        chk(tx_empty == 1'b1, "R5", "tx_empty after", tx_empty, 1);
        read_rx();

        // R6: receive disabled
        prev_rb = rx_rdata;
        @(negedge clk); rx_en = 1'b0;
        ri = rxirq_n;
        xfer(8'hC3, 8'h99);
        chk(peer_rx == 8'hC3, "R6", "still transmits", peer_rx, 8'hC3);
        chk(rx_rdata == prev_rb, "R6", "rbuf untouched", rx_rdata, prev_rb);
        chk(rx_valid == 1'b0 && rxirq_n == ri, "R6", "no receive", {rx_valid, 8'(rxirq_n - ri)}, 0);
        @(negedge clk); rx_en = 1'b1;

        // R9: overrun, sticky, cleared by ovr_clr
        xfer(8'h01, 8'h21);
        ri = rxirq_n;
        xfer(8'h02, 8'h42);
        chk(overrun == 1'b1, "R9", "overrun set", overrun, 1);
        chk(rx_valid == 1'b0, "R9", "valid low on ovr", rx_valid, 0);
        chk(rxirq_n == ri, "R9", "no rx_irq on ovr", rxirq_n - ri, 0);
        repeat (50) @(negedge clk);
        chk(overrun == 1'b1, "R9", "overrun sticky", overrun, 1);
        pulse_ovr_clr();
        chk(overrun == 1'b0, "R9", "ovr_clr", overrun, 0);
        read_rx();

        // R9: cleared by rx_en low
        xfer(8'h03, 8'h63);
        xfer(8'h04, 8'h84);
        chk(overrun == 1'b1, "R9", "overrun again", overrun, 1);
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk); rx_en = 1'b1;
        chk(overrun == 1'b0, "R9", "rx_en clears", overrun, 0);
        read_rx();

        // R9: read before 7th bit avoids overrun
        xfer(8'h05, 8'h15);
        arm_peer(8'hE7);
        write_tx(8'h06);
        wait_trails(3);
        read_rx();
        wait_done();
        chk(overrun == 1'b0, "R9", "early read no ovr", overrun, 0);
        chk(rx_valid == 1'b1 && rx_rdata == 8'hE7, "R9", "early read data", rx_rdata, 8'hE7);
        read_rx();

        // R9: read after 7th bit is too late
        xfer(8'h07, 8'h17);
        arm_peer(8'h77);
        write_tx(8'h08);
        wait_trails(7);
        read_rx();
        wait_done();
        chk(overrun == 1'b1, "R9", "late read ovr", overrun, 1);
        pulse_ovr_clr();
        read_rx();

        // R10: read without continuous mode starts nothing
        arm_peer(8'h55);
        read_rx();
        repeat (100) @(negedge clk);
        chk(lead_n == 0, "R10", "no rearm when off", lead_n, 0);
        armed = 1'b0;

        // R10: continuous mode rearm sends ones
        @(negedge clk); cont_rx = 1'b1; irq_sel = 1'b0;
        ti = txirq_n;
        arm_peer(8'hB6);
        read_rx();
        wait_done();
        @(negedge clk); cont_rx = 1'b0;
        chk(peer_rx == 8'hFF, "R10", "dummy ones", peer_rx, 8'hFF);
        chk(rx_rdata == 8'hB6 && rx_valid, "R10", "received", rx_rdata, 8'hB6);
        chk(txirq_n == ti, "R10", "no tx_irq", txirq_n - ti, 0);
        read_rx();

        // R11: external clock, polarity 1, MSB first
        @(negedge clk); ext_sel = 1'b1; clk_pol = 1'b1; msb = 1'b1; sclk_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(sclk_oe == 1'b0, "R11", "sclk_oe", sclk_oe, 0);
        tw = 8'h9D; pw = 8'h2B; peer_rx = 8'h00;
        write_tx(tw);
        for (int i = 0; i < 8; i++) begin
            repeat (6) @(negedge clk);
            sclk_in = 1'b1; rxd = get_bit(pw, i, 1'b1);
            repeat (6) @(negedge clk);
            peer_rx = put_bit(peer_rx, i, 1'b1, txd);
            sclk_in = 1'b0;
        end
        repeat (8) @(negedge clk);
        chk(peer_rx == tw, "R11", "ext tx word", peer_rx, tw);
        chk(rx_rdata == pw && rx_valid, "R11", "ext rx word", rx_rdata, pw);
        chk(tx_empty == 1'b1, "R11", "ext done", tx_empty, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule